// File: doc/BRIEF.md
# Auto-Reload Timer with PWM

An 8-bit up-counting timer/counter that raises a sticky interrupt flag each time it rolls past its top value. At each rollover it copies a separate reload register into the count. The count interval is therefore 256 minus the reload value, measured in counting ticks. A tick is either a CPU clock divided by a programmable power of two, or a chosen edge of an external event input.

The same count drives a pulse-width output. While the timer runs, the waveform starts each period at the reload value. It stays high until the count reaches a duty value and then stays low until the next rollover. A single enable bit chooses whether the pin carries this waveform or the ordinary port latch value.

Software reaches four byte-wide registers through a simple write strobe with an address. Reads are combinational. Address 0 is mode, 1 is count, 2 is reload and 3 is duty.

Top module: `reload_pwm_timer`

## Requirements
- R1: Mode bit 7 runs the timer. While it is clear, the count holds its value and the prescaler is held at zero. All state resets to zero, including the four registers, the flag and the prescaler.
- R2: In internal mode (mode bit 2 = 0), rate field mode[6:4] = r gives one tick every 2^(7-r) clock cycles. Code 0 divides by 128, code 6 by 2 and code 7 by 1. After the enabling write, the flag rises (256 - reload) * 2^(7-r) cycles later, provided count was preloaded with reload.
- R3: A tick at count 0xFF sets the interrupt flag and loads the count from the reload register.
- R4: The flag stays set until irq_ack is high at a clock edge. A rollover in the same cycle as irq_ack leaves the flag set.
- R5: With mode bit 2 = 1, the rate field is ignored. Each edge of event_in increments the count once. The edge is seen through a two-stage synchronizer; mode bit 3 = 0 selects rising edges and 1 selects falling edges.
- R6: With mode bit 0 clear, pwm_pin equals latch_out. With it set, pwm_pin carries the waveform and ignores latch_out.
- R7: With the waveform selected, pwm_pin is high while count < duty and low otherwise. Over one period of 256 - reload ticks it is high for max(0, duty - reload) ticks.
- R8: A write to the reload register does not disturb the running count. The new value is first used at the next rollover.
- R9: A write to the count register takes effect at the next edge and overrides any tick in that cycle, including a rollover, which then neither reloads nor sets the flag.
- R10: rdata returns mode, count, reload or duty for addr 0, 1, 2 or 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 mode, 1 count, 2 reload, 3 duty |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| irq_ack | input | 1 | Clears the interrupt flag |
| event_in | input | 1 | External event input, asynchronous |
| latch_out | input | 1 | Ordinary port latch value for the pin |
| irq | output | 1 | Interrupt request flag |
| pwm_pin | output | 1 | Pin drive: waveform or latch value |

## Verification
The embedded properties assume that event_in pulses stay high and low for at least two clock cycles, so that the synchronizer cannot merge or drop edges. They also assume that addr and wdata are stable whenever wr_en is high. The stimulus changes every input only on falling clock edges and holds each event level for three cycles. The per-cycle step property allows a count change of at most one unless a rollover or a count write occurs, and every test respects that.

// File: rtl/reload_pwm_timer.sv
module reload_pwm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         irq_ack,
  input  logic         event_in,
  input  logic         latch_out,
  output logic         irq,
  output logic         pwm_pin
);
  localparam int RATE_W = 3;
  localparam int PS_W = (1 << RATE_W) - 1;
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0]    mode_q, cnt_q, reload_q, duty_q;
  logic [PS_W-1:0] ps_q, ps_mask;
  logic [2:0]      ev_q;
  logic            irq_q;

  logic              run, use_ev, ev_fall, pwm_on;
  logic [RATE_W-1:0] rate;
  logic              cnt_wr, ev_edge, ps_tick, tick, ovf;

  assign run     = mode_q[7];
  assign rate    = mode_q[6:4];
  assign ev_fall = mode_q[3];
  assign use_ev  = mode_q[2];
  assign pwm_on  = mode_q[0];

  assign ps_mask = {PS_W{1'b1}} >> rate;
  assign ps_tick = (ps_q & ps_mask) == ps_mask;
  assign ev_edge = ev_fall ? (ev_q[2] & ~ev_q[1]) : (ev_q[1] & ~ev_q[2]);
  assign tick    = run & (use_ev ? ev_edge : ps_tick);
  assign cnt_wr  = wr_en && (addr == 2'd1);
  assign ovf     = tick && (cnt_q == TOP) && !cnt_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      cnt_q    <= '0;
      reload_q <= '0;
      duty_q   <= '0;
      ps_q     <= '0;
      ev_q     <= '0;
      irq_q    <= 1'b0;
    end else begin
      ev_q <= {ev_q[1:0], event_in};
      ps_q <= run ? ps_q + 1'b1 : '0;

      if (wr_en) begin
        case (addr)
          2'd0:    mode_q   <= wdata;
          2'd2:    reload_q <= wdata;
          2'd3:    duty_q   <= wdata;
          default: ;
        endcase
      end

      if (cnt_wr)
        cnt_q <= wdata;
      else if (tick)
        cnt_q <= (cnt_q == TOP) ? reload_q : cnt_q + 1'b1;

      if (ovf)
        irq_q <= 1'b1;
      else if (irq_ack)
        irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = mode_q;
      2'd1:    rdata = cnt_q;
      2'd2:    rdata = reload_q;
      default: rdata = duty_q;
    endcase
  end

  assign irq     = irq_q;
  assign pwm_pin = pwm_on ? (cnt_q < duty_q) : latch_out;

  // R3
  ovf_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> irq_q);

  // R3
  ovf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt_q == $past(reload_q));

  // R4
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_ack |=> irq_q);

  // R1
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr |=> $stable(cnt_q));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr && cnt_q != TOP |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  // R9
  cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(wdata));
endmodule

// File: tb/tb_reload_pwm_timer.sv
module tb_reload_pwm_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq_ack = 1'b0;
  logic       event_in = 1'b0;
  logic       latch_out = 1'b0;
  logic       irq, pwm_pin;

  int n_chk = 0;
  int n_err = 0;

  // {rate[7:0], reload[7:0], expected cycles[15:0]}
  localparam logic [31:0] VEC [5] = '{
    32'h07FE_0002, 32'h06FC_0008, 32'h00F0_0800, 32'h0300_1000, 32'h0580_0200
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_ack(irq_ack), .event_in(event_in),
    .latch_out(latch_out), .irq(irq), .pwm_pin(pwm_pin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); event_in = 1'b1;
      wait_cyc(2);
      @(negedge clk); event_in = 1'b0;
      wait_cyc(2);
    end
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_pin) h++;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, v2;
    int k, h;

    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;

    // R10 / R1: reset values
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R10 reset register", {24'd0, v}, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);

    // R2 / R3: interval per rate code, walked from the table
    for (int i = 0; i < 5; i++) begin
      wr(2'd0, 8'h00);
      ack();
      wr(2'd2, VEC[i][23:16]);
      wr(2'd1, VEC[i][23:16]);
      wr(2'd0, {1'b1, VEC[i][26:24], 4'b0000});
      k = 0;
      while (!irq && k < 5000) begin
        @(negedge clk);
        k++;
      end
      chk("R2 interval cycles", k, {16'd0, VEC[i][15:0]});
      chk("R3 flag set on rollover", {31'd0, irq}, 32'd1);
      rd(2'd1, v);
      chk("R3 count reloaded", {24'd0, v}, {24'd0, VEC[i][23:16]});
    end

    // R4: sticky flag, cleared by acknowledge
    wr(2'd0, 8'h00);
    wait_cyc(10);
    chk("R4 flag holds", {31'd0, irq}, 32'd1);
    ack();
    chk("R4 flag cleared", {31'd0, irq}, 32'd0);

    // R8: reload write does not disturb the count
    wr(2'd2, 8'hF0);
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hF0);
    wait_cyc(3);
    rd(2'd1, v);
    chk("R2 undivided count", {24'd0, v}, 32'hF3);
    wr(2'd2, 8'hE0);
    rd(2'd1, v);
    chk("R8 count undisturbed", {24'd0, v}, 32'hF5);
    k = 0;
    while (!irq && k < 100) begin
      @(negedge clk);
      k++;
    end
    rd(2'd1, v);
    chk("R8 new reload used at rollover", {24'd0, v}, 32'hE0);

    // R9: count write overrides tick
    wr(2'd1, 8'h10);
    rd(2'd1, v);
    chk("R9 count write", {24'd0, v}, 32'h10);

    // R1: disabled count holds
    wr(2'd0, 8'h00);
    rd(2'd1, v);
    wait_cyc(20);
    rd(2'd1, v2);
    chk("R1 count frozen", {24'd0, v2}, {24'd0, v});

    // R4: rollover beats acknowledge
    irq_ack = 1'b1;
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'hFE);
    wr(2'd0, 8'hF0);
    wait_cyc(4);
    chk("R4 set wins over ack", {31'd0, irq}, 32'd1);
    wr(2'd0, 8'h00);
    wait_cyc(2);
    chk("R4 ack clears when idle", {31'd0, irq}, 32'd0);
    irq_ack = 1'b0;

    // R5: event counting, rate ignored
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h84);
    wait_cyc(300);
    rd(2'd1, v);
    chk("R5 no events no count", {24'd0, v}, 32'h20);
    pulses(5);
    wait_cyc(5);
    rd(2'd1, v);
    chk("R5 rising edges counted", {24'd0, v}, 32'h25);
    wr(2'd0, 8'h8C);
    pulses(3);
    wait_cyc(5);
    rd(2'd1, v);
    chk("R5 falling edges counted", {24'd0, v}, 32'h28);

    // R6: latch path when waveform is off
    wr(2'd0, 8'h00);
    @(negedge clk) latch_out = 1'b1;
    #1 chk("R6 latch high", {31'd0, pwm_pin}, 32'd1);
    @(negedge clk) latch_out = 1'b0;
    #1 chk("R6 latch low", {31'd0, pwm_pin}, 32'd0);

    // R7: duty compare, period from reload
    wr(2'd3, 8'hF8);
    wr(2'd2, 8'hF0);
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'hF1);
    rd(2'd0, v);
    chk("R10 mode readback", {24'd0, v}, 32'hF1);
    latch_out = 1'b1;
    count_high(64, h);
    chk("R7 half duty highs", h, 32);
    wr(2'd3, 8'hFF);
    rd(2'd3, v);
    chk("R10 duty readback", {24'd0, v}, 32'hFF);
    count_high(64, h);
    chk("R7 high duty highs", h, 60);
    wr(2'd3, 8'hF0);
    count_high(64, h);
    chk("R7 duty at reload stays low", h, 0);
    wr(2'd0, 8'h00);
    #1 chk("R6 back to latch", {31'd0, pwm_pin}, 32'd1);

    finish_run();
  end
endmodule